// File: doc/BRIEF.md
# PMU User-Enable Register Access Trap Prioritizer

This block decides, in a single combinational pass, what happens to an instruction that tries to read or write the register that grants user-level software access to the performance monitors. The block takes three kinds of input. The first is the privilege level of the requester, from 0 to 3. The second is the direction of the access. The third is a set of global configuration flags. These flags cover the presence and enablement of the higher levels, host mode, fine-grained trap support with its per-direction trap bits, the level-2 and level-3 PMU trap bits, and two secure-debug "make it undefined" conditions. The block returns exactly one outcome: perform the access, treat it as undefined, trap to level 2, or trap to level 3.

The checks run in a fixed priority that depends on both level and direction. A level-3 undefined condition is checked first, then the fine-grained trap, then the level-2 PMU trap, then the level-3 PMU trap. Level 2 sees only the level-3 checks. Level 3 never traps. The block also decodes the system-register encoding fields. A result is marked valid only for a requested access that names this register. A trap outcome carries the exception class code used by the syndrome. Taking the exception and holding the register contents belong to neighbouring logic.

All pins are plain combinational control and status signals. There is no data stream, so there is no back-pressure. The result follows the inputs in the same cycle.

Top module: `pmu_uacc_trap_resolver`

## Requirements
- R1: `res_valid` is 1 only when `req_valid` is 1 and the encoding is op0=2'b11, op1=3'b011, crn=4'b1001, crm=4'b1110, op2=3'b000; when `res_valid` is 0, `res_code` is 2'b00 and `res_class` is 0.
- R2: `res_code` uses 2'b00 = perform, 2'b01 = undefined, 2'b10 = trap to level 2, 2'b11 = trap to level 3; `res_class` is 6'h18 on both trap codes and 0 on every other result.
- R3: An access at level 3 is always performed, whatever the configuration.
- R4: A write at level 0 is always undefined, whatever the configuration.
- R5: At levels 0, 1 and 2, if level 3 is present, the priority-undefined condition holds and the level-3 PMU trap bit is set, the result is undefined, ahead of every other check.
- R6: At levels 0 and 1, the fine-grained trap goes to level 2 when all of these hold: level 2 is enabled, fine-grained traps are implemented, level 3 is absent or has fine-grained traps enabled, and the trap bit for the access direction is set. Reads use `cfg_fgt_rd`; writes use `cfg_fgt_wr`. This check ranks below R5.
- R7: At level 0, host mode suppresses the fine-grained trap only. The level-2 PMU trap still applies in host mode.
- R8: At levels 0 and 1, if level 2 is enabled and its PMU trap bit is set, the result is a trap to level 2. This check ranks below R6.
- R9: At levels 0, 1 and 2, if level 3 is present and its PMU trap bit is set, the result is a trap to level 3, or undefined when `cfg_sdd_undef` is 1. This check ranks below R8.
- R10: At level 2, the fine-grained trap bits, host mode and the level-2 PMU trap bit have no effect on the result.
- R11: Any valid access that none of the rules above catches is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | An access request is present |
| req_level | input | 2 | Privilege level of the requester (0 to 3) |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cfg_l2_enabled | input | 1 | Level 2 is enabled for the current security state |
| cfg_l3_present | input | 1 | Level 3 is implemented |
| cfg_host_mode | input | 1 | Level 0 runs under a host at level 2 |
| cfg_fgt_impl | input | 1 | Fine-grained traps are implemented |
| cfg_fgt_l3_en | input | 1 | Level 3 enables fine-grained traps |
| cfg_fgt_rd | input | 1 | Fine-grained read-trap bit for this register |
| cfg_fgt_wr | input | 1 | Fine-grained write-trap bit for this register |
| cfg_l2_pm_trap | input | 1 | Level-2 PMU trap bit |
| cfg_l3_pm_trap | input | 1 | Level-3 PMU trap bit |
| cfg_sdd_undef_prio | input | 1 | Secure-debug undefined condition that outranks traps |
| cfg_sdd_undef | input | 1 | Secure-debug undefined condition that replaces a level-3 trap |
| res_valid | output | 1 | Result applies to a request for this register |
| res_code | output | 2 | Outcome code (see R2) |
| res_class | output | 6 | Exception class for trap outcomes, else 0 |

## Verification
The block holds no state, so a wrong priority order or a wrong qualifying term shows up on `res_code` in the same evaluation as the input pattern that exposes it. Nothing is hidden that could surface later. The risk is coverage, not latency. The level, direction and eleven configuration flags are swept over every combination, and each result is compared against an independent rule-by-rule model. Any misordered check therefore appears on at least one vector. Mismatched encodings and idle requests are added to confirm that the result and class are zero.

// File: rtl/pmu_uacc_pkg.sv
package pmu_uacc_pkg;
  localparam int LEVEL_W = 2;
  localparam int CLASS_W = 6;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

  typedef enum logic [1:0] {
    RES_PERFORM = 2'b00,
    RES_UNDEF   = 2'b01,
    RES_TRAP_L2 = 2'b10,
    RES_TRAP_L3 = 2'b11
  } res_code_e;

  localparam logic [LEVEL_W-1:0] LVL_USER  = 2'd0;
  localparam logic [LEVEL_W-1:0] LVL_KERN  = 2'd1;
  localparam logic [LEVEL_W-1:0] LVL_HYP   = 2'd2;
  localparam logic [LEVEL_W-1:0] LVL_MON   = 2'd3;
endpackage

// File: rtl/pmu_uacc_enc_match.sv
module pmu_uacc_enc_match #(
  parameter int OP0_W = 2,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [OP0_W-1:0] OP0_V = 2'b11,
  parameter logic [OP1_W-1:0] OP1_V = 3'b011,
  parameter logic [CRN_W-1:0] CRN_V = 4'b1001,
  parameter logic [CRM_W-1:0] CRM_V = 4'b1110,
  parameter logic [OP2_W-1:0] OP2_V = 3'b000
) (
  input  logic [OP0_W-1:0] op0,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);
  localparam int KEY_W = OP0_W + OP1_W + CRN_W + CRM_W + OP2_W;
  localparam logic [KEY_W-1:0] KEY_V = {OP0_V, OP1_V, CRN_V, CRM_V, OP2_V};

  logic [KEY_W-1:0] key;
  assign key = {op0, op1, crn, crm, op2};
  assign hit = (key == KEY_V);
endmodule

// File: rtl/pmu_uacc_fgt_qual.sv
module pmu_uacc_fgt_qual
  import pmu_uacc_pkg::*;
(
  input  logic [LEVEL_W-1:0] level,
  input  logic               is_write,
  input  logic               l2_enabled,
  input  logic               l3_present,
  input  logic               host_mode,
  input  logic               fgt_impl,
  input  logic               fgt_l3_en,
  input  logic               fgt_rd,
  input  logic               fgt_wr,
  output logic               fire
);
  logic lvl_ok;
  logic gate_ok;
  logic dir_bit;

  always_comb begin
    unique case (level)
      LVL_USER: lvl_ok = !host_mode;
      LVL_KERN: lvl_ok = 1'b1;
      default:  lvl_ok = 1'b0;
    endcase
  end

  assign gate_ok = l2_enabled & fgt_impl & (!l3_present | fgt_l3_en);
  assign dir_bit = is_write ? fgt_wr : fgt_rd;
  assign fire    = lvl_ok & gate_ok & dir_bit;
endmodule

// File: rtl/pmu_uacc_prio_chain.sv
module pmu_uacc_prio_chain
  import pmu_uacc_pkg::*;
(
  input  logic [LEVEL_W-1:0] level,
  input  logic               is_write,
  input  logic               fgt_fire,
  input  logic               l2_enabled,
  input  logic               l3_present,
  input  logic               l2_pm_trap,
  input  logic               l3_pm_trap,
  input  logic               sdd_undef_prio,
  input  logic               sdd_undef,
  output res_code_e          code
);
  logic      early_undef;
  logic      l2_pm_hit;
  logic      l3_pm_hit;
  res_code_e l3_result;
  res_code_e low_chain;
  res_code_e hyp_chain;

  assign early_undef = l3_present & sdd_undef_prio & l3_pm_trap;
  assign l2_pm_hit   = l2_enabled & l2_pm_trap;
  assign l3_pm_hit   = l3_present & l3_pm_trap;
  assign l3_result   = sdd_undef ? RES_UNDEF : RES_TRAP_L3;

  always_comb begin
    if (early_undef)     low_chain = RES_UNDEF;
    else if (fgt_fire)   low_chain = RES_TRAP_L2;
    else if (l2_pm_hit)  low_chain = RES_TRAP_L2;
    else if (l3_pm_hit)  low_chain = l3_result;
    else                 low_chain = RES_PERFORM;
  end

  always_comb begin
    if (early_undef)     hyp_chain = RES_UNDEF;
    else if (l3_pm_hit)  hyp_chain = l3_result;
    else                 hyp_chain = RES_PERFORM;
  end

  always_comb begin
    unique case (level)
      LVL_USER: code = is_write ? RES_UNDEF : low_chain;
      LVL_KERN: code = low_chain;
      LVL_HYP:  code = hyp_chain;
      default:  code = RES_PERFORM;
    endcase
  end
endmodule

// File: rtl/pmu_uacc_trap_resolver.sv
module pmu_uacc_trap_resolver
  import pmu_uacc_pkg::*;
(
  input  logic               req_valid,
  input  logic [LEVEL_W-1:0] req_level,
  input  logic               req_is_write,
  input  logic [1:0]         req_op0,
  input  logic [2:0]         req_op1,
  input  logic [3:0]         req_crn,
  input  logic [3:0]         req_crm,
  input  logic [2:0]         req_op2,
  input  logic               cfg_l2_enabled,
  input  logic               cfg_l3_present,
  input  logic               cfg_host_mode,
  input  logic               cfg_fgt_impl,
  input  logic               cfg_fgt_l3_en,
  input  logic               cfg_fgt_rd,
  input  logic               cfg_fgt_wr,
  input  logic               cfg_l2_pm_trap,
  input  logic               cfg_l3_pm_trap,
  input  logic               cfg_sdd_undef_prio,
  input  logic               cfg_sdd_undef,
  output logic               res_valid,
  output logic [1:0]         res_code,
  output logic [CLASS_W-1:0] res_class
);
  logic      enc_hit;
  logic      fgt_fire;
  res_code_e chain_code;

  pmu_uacc_enc_match u_match (
    .op0 (req_op0),
    .op1 (req_op1),
    .crn (req_crn),
    .crm (req_crm),
    .op2 (req_op2),
    .hit (enc_hit)
  );

  pmu_uacc_fgt_qual u_fgt (
    .level      (req_level),
    .is_write   (req_is_write),
    .l2_enabled (cfg_l2_enabled),
    .l3_present (cfg_l3_present),
    .host_mode  (cfg_host_mode),
    .fgt_impl   (cfg_fgt_impl),
    .fgt_l3_en  (cfg_fgt_l3_en),
    .fgt_rd     (cfg_fgt_rd),
    .fgt_wr     (cfg_fgt_wr),
    .fire       (fgt_fire)
  );

  pmu_uacc_prio_chain u_chain (
    .level          (req_level),
    .is_write       (req_is_write),
    .fgt_fire       (fgt_fire),
    .l2_enabled     (cfg_l2_enabled),
    .l3_present     (cfg_l3_present),
    .l2_pm_trap     (cfg_l2_pm_trap),
    .l3_pm_trap     (cfg_l3_pm_trap),
    .sdd_undef_prio (cfg_sdd_undef_prio),
    .sdd_undef      (cfg_sdd_undef),
    .code           (chain_code)
  );

  always_comb begin
    res_valid = req_valid & enc_hit;
    res_code  = res_valid ? chain_code : RES_PERFORM;
    unique case (res_code)
      RES_TRAP_L2, RES_TRAP_L3: res_class = TRAP_CLASS;
      default:                  res_class = '0;
    endcase
  end
endmodule

// File: rtl/pmu_uacc_checker.sv
module pmu_uacc_checker
  import pmu_uacc_pkg::*;
(
  input logic               req_valid,
  input logic [LEVEL_W-1:0] req_level,
  input logic               req_is_write,
  input logic               cfg_l3_present,
  input logic               cfg_l3_pm_trap,
  input logic               cfg_sdd_undef_prio,
  input logic               res_valid,
  input logic [1:0]         res_code,
  input logic [CLASS_W-1:0] res_class
);
  always_comb begin
    // R1: no result without a request
    a_r1_idle_quiet: assert (req_valid || (!res_valid && res_code == 2'b00 && res_class == '0));
    // R2: class present exactly on trap codes
    a_r2_class_on_trap: assert ((res_code[1] && res_class == TRAP_CLASS) || (!res_code[1] && res_class == '0));
    // R3: top level never stopped
    a_r3_top_performs: assert (!(res_valid && req_level == LVL_MON) || res_code == 2'b00);
    // R4: user write undefined
    a_r4_user_write: assert (!(res_valid && req_level == LVL_USER && req_is_write) || res_code == 2'b01);
    // R5: early undefined outranks everything below level 3
    a_r5_early_undef: assert (!(res_valid && req_level != LVL_MON && cfg_l3_present
                                && cfg_sdd_undef_prio && cfg_l3_pm_trap) || res_code == 2'b01);
    // R9: no level-3 trap without level 3 present
    a_r9_no_l3_absent: assert (cfg_l3_present || res_code != 2'b11);
    // R10: level 2 never traps to itself
    a_r10_hyp_no_l2: assert (!(res_valid && req_level == LVL_HYP) || res_code != 2'b10);
  end
endmodule

bind pmu_uacc_trap_resolver pmu_uacc_checker u_chk (
  .req_valid          (req_valid),
  .req_level          (req_level),
  .req_is_write       (req_is_write),
  .cfg_l3_present     (cfg_l3_present),
  .cfg_l3_pm_trap     (cfg_l3_pm_trap),
  .cfg_sdd_undef_prio (cfg_sdd_undef_prio),
  .res_valid          (res_valid),
  .res_code           (res_code),
  .res_class          (res_class)
);

// File: tb/pmu_uacc_trap_resolver_test.sv
`timescale 1ns/1ps
module pmu_uacc_trap_resolver_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       req_valid = 1'b0;
  logic [1:0] req_level = '0;
  logic       req_is_write = 1'b0;
  logic [1:0] req_op0 = '0;
  logic [2:0] req_op1 = '0;
  logic [3:0] req_crn = '0;
  logic [3:0] req_crm = '0;
  logic [2:0] req_op2 = '0;
  logic cfg_l2_enabled = 0, cfg_l3_present = 0, cfg_host_mode = 0, cfg_fgt_impl = 0;
  logic cfg_fgt_l3_en = 0, cfg_fgt_rd = 0, cfg_fgt_wr = 0, cfg_l2_pm_trap = 0;
  logic cfg_l3_pm_trap = 0, cfg_sdd_undef_prio = 0, cfg_sdd_undef = 0;
  logic       res_valid;
  logic [1:0] res_code;
  logic [5:0] res_class;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pmu_uacc_trap_resolver uut (.*);

  // Reference: each rule written as in the requirement list
  function automatic void model(output logic v, output logic [1:0] c, output logic [5:0] k,
                                output string tag);
    bit enc_ok, fg;
    enc_ok = (req_op0 == 2'd3) && (req_op1 == 3'd3) && (req_crn == 4'd9)
             && (req_crm == 4'd14) && (req_op2 == 3'd0);
    v = req_valid && enc_ok;
    fg = cfg_l2_enabled && cfg_fgt_impl && (!cfg_l3_present || cfg_fgt_l3_en)
         && (req_is_write ? cfg_fgt_wr : cfg_fgt_rd);
    if (!v)                                     begin c = 0; tag = "R1"; end
    else if (req_level == 3)                    begin c = 0; tag = "R3"; end
    else if (req_level == 0 && req_is_write)    begin c = 1; tag = "R4"; end
    else if (cfg_l3_present && cfg_sdd_undef_prio && cfg_l3_pm_trap)
                                                begin c = 1; tag = "R5"; end
    else if (req_level == 2) begin
      if (cfg_l3_present && cfg_l3_pm_trap)     begin c = cfg_sdd_undef ? 2'd1 : 2'd3; tag = "R10"; end
      else                                      begin c = 0; tag = "R10"; end
    end
    else if (fg && req_level == 0 && cfg_host_mode && cfg_l2_enabled && cfg_l2_pm_trap)
                                                begin c = 2; tag = "R7"; end
    else if (fg && !(req_level == 0 && cfg_host_mode))
                                                begin c = 2; tag = "R6"; end
    else if (cfg_l2_enabled && cfg_l2_pm_trap)  begin c = 2; tag = "R8"; end
    else if (cfg_l3_present && cfg_l3_pm_trap)  begin c = cfg_sdd_undef ? 2'd1 : 2'd3; tag = "R9"; end
    else                                        begin c = 0; tag = "R11"; end
    k = (c >= 2) ? 6'h18 : 6'h00;
  endfunction

  task automatic compare(input string forced_tag);
    logic ev; logic [1:0] ec; logic [5:0] ek; string t;
    model(ev, ec, ek, t);
    if (forced_tag != "") t = forced_tag;
    checks++;
    if (res_valid !== ev || res_code !== ec || res_class !== ek) begin
      fails++;
      $display("FAIL %s: got valid=%0b code=%0d class=%h, expected valid=%0b code=%0d class=%h",
               t, res_valid, res_code, res_class, ev, ec, ek);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    compare(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic set_enc(input bit good);
    req_op0 = 2'b11; req_op1 = 3'b011; req_crn = 4'b1001; req_crm = 4'b1110;
    req_op2 = good ? 3'b000 : 3'b001;
  endtask

  task automatic set_cfg(input logic [10:0] f);
    {cfg_l2_enabled, cfg_l3_present, cfg_host_mode, cfg_fgt_impl, cfg_fgt_l3_en,
     cfg_fgt_rd, cfg_fgt_wr, cfg_l2_pm_trap, cfg_l3_pm_trap, cfg_sdd_undef_prio,
     cfg_sdd_undef} = f;
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got no end, expected end of test");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    // Reset state: idle request gives an empty result (R1)
    step("R1");
    rst = 1'b0;
    @(posedge clk); #1;

    // Directed corners
    set_enc(1'b1); req_valid = 1;
    req_level = 3; set_cfg(11'h7FF); step("R3");
    req_level = 0; req_is_write = 1; set_cfg(11'h000); step("R4");
    req_level = 1; req_is_write = 0;
    cfg_l3_present = 1; cfg_l3_pm_trap = 1; cfg_sdd_undef_prio = 1;
    cfg_l2_enabled = 1; cfg_l2_pm_trap = 1; step("R5");
    set_cfg(11'h000); cfg_l2_enabled = 1; cfg_fgt_impl = 1; cfg_fgt_rd = 1; step("R6");
    req_is_write = 1; step("R6");           // write ignores read bit -> perform
    cfg_fgt_wr = 1; step("R6");
    req_level = 0; req_is_write = 0; cfg_host_mode = 1; step("R7");
    cfg_l2_pm_trap = 1; step("R7");
    set_cfg(11'h000); req_level = 1; cfg_l2_enabled = 1; cfg_l2_pm_trap = 1;
    cfg_l3_present = 1; cfg_l3_pm_trap = 1; step("R8");
    cfg_l2_pm_trap = 0; step("R9");
    cfg_sdd_undef = 1; step("R9");
    req_level = 2; set_cfg(11'h000); cfg_l2_enabled = 1; cfg_fgt_impl = 1;
    cfg_fgt_rd = 1; cfg_l2_pm_trap = 1; cfg_host_mode = 1; step("R10");
    req_level = 1; set_cfg(11'h000); step("R11");
    set_enc(1'b0); set_cfg(11'h7FF); step("R1");
    req_valid = 0; set_enc(1'b1); step("R1");

    // Exhaustive sweep, compared every clock
    req_valid = 1;
    for (int i = 0; i < 16384; i++) begin
      {req_level, req_is_write} = 3'(i >> 11);
      set_cfg(11'(i));
      step("");
    end
    // Encoding mismatch on each field (R1)
    for (int j = 0; j < 5; j++) begin
      set_enc(1'b1); set_cfg(11'h000); req_level = 1; req_is_write = 0;
      case (j)
        0: req_op0 = 2'b10;
        1: req_op1 = 3'b010;
        2: req_crn = 4'b1000;
        3: req_crm = 4'b1100;
        default: req_op2 = 3'b100;
      endcase
      step("R1");
    end
    // R2: class only with trap codes, covered by every compare above
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule